// File: doc/BRIEF.md
# Multiplexed Bus Strobe Generator

This block runs single transfers on an external bus whose sixteen lines carry first an address and then data. A requester presents a read or a write, a byte or a word, an address and write data. The block then steps through an address phase, a strobe phase and a recovery phase. During these phases it drives the shared lines and the control strobes that external latches and memories expect. When the transfer ends it pulses `done`. For a read, the gathered data is on `rd_data` at that point.

Two configuration inputs pick one of four strobe sets. `cfg_ale_mode` chooses between a high-true address latch pulse (`ale`) and a low-true address-valid strobe held for the whole transfer (`adv_n`). `cfg_wr_mode` chooses between one write strobe with a high-byte enable (`wr_n`, `bhe_n`) and a pair of lane write strobes (`wrl_n`, `wrh_n`). Only one read strobe exists: a byte read on the wide bus fetches both lanes and the block keeps the byte it wants.

When `dyn_width_en` is set, the external decoder can pull `bus_width_n` low during the address phase. That turns the transfer into an 8-bit one, where data moves on the low lane and the upper address byte stays on the high lane. A word access on an 8-bit transfer becomes two back-to-back byte transfers, low byte first.

The sequencer has four states:
- IDLE waits for a request.
- IDLE→ADDR on an accepted request.
- ADDR→STRB always.
- STRB→RCVR always.
- RCVR→ADDR for the second half of a split word.
- RCVR→IDLE otherwise, with `done`.

Top module: `mbus_strobe_gen`

## Requirements
- R1: While reset is held and right after it: `req_ready`=1, `done`=0, `ale`=0, `adv_n`=1, `rd_n`=`wr_n`=`bhe_n`=`wrl_n`=`wrh_n`=1, `ad_oe_lo`=`ad_oe_hi`=0.
- R2: `req_ready` is 1 only in IDLE. A request with `req_valid`=1 in IDLE is taken at that clock edge. The bus then spends exactly one cycle each in the address, strobe and recovery phases. `done` is 1 for one cycle, the cycle after the last recovery phase.
- R3: With `cfg_ale_mode`=1, `ale` is 1 exactly in the address phase and `adv_n` stays 1. With `cfg_ale_mode`=0, `ale` stays 0 and `adv_n` is 0 from the address phase through the recovery phase.
- R4: In the address phase both lane enables are 1. `ad_out` carries the address with bit 0 set to the byte being addressed. That bit is 0 for a word on the 16-bit bus, and 0 then 1 for the two halves of a split word.
- R5: `rd_n` is 0 exactly in the strobe phase of a read. In that phase `ad_oe_lo`=0, and `ad_oe_hi`=0 too on a 16-bit transfer.
- R6: With `cfg_wr_mode`=1, `wr_n` is 0 exactly in the strobe phase of a write, and `wrl_n`, `wrh_n` stay 1.
- R7: With `cfg_wr_mode`=1, `bhe_n` is 0 across all three phases when the transfer touches the high byte. On a 16-bit transfer that means a word or an odd address. On an 8-bit transfer it means address bit 0 = 1. With `cfg_wr_mode`=0, `bhe_n` stays 1.
- R8: With `cfg_wr_mode`=0, `wr_n` stays 1. In a write's strobe phase, `wrl_n` is 0 on any 8-bit transfer, or on a 16-bit transfer with address bit 0 = 0. `wrh_n` is 0 on a 16-bit transfer that touches the high byte.
- R9: In a write's strobe phase both lanes are driven. On the 16-bit bus a word goes out whole and a byte goes out copied onto both lanes. On an 8-bit transfer `ad_out`[7:0] holds the byte and `ad_out`[15:8] holds the upper address byte.
- R10: `rd_data` at `done` depends on the access. A word read returns the high-address byte in [15:8] and the even byte in [7:0]. A byte read returns the addressed byte in [7:0] with [15:8]=0. Read data is sampled from `ad_in` at the end of the strobe phase.
- R11: A transfer is 8-bit only when `dyn_width_en`=1 and `bus_width_n`=0 at the end of the address phase. Otherwise `bus_width_n` has no effect. On an 8-bit transfer `ad_oe_hi` stays 1 and `ad_out`[15:8] holds the upper address byte through the recovery phase.
- R12: A word access on an 8-bit transfer runs as two full address/strobe/recovery sequences, low byte first. It gives a single `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ale_mode | input | 1 | 1: latch pulse `ale`; 0: `adv_n` strobe |
| cfg_wr_mode | input | 1 | 1: `wr_n` with `bhe_n`; 0: `wrl_n`/`wrh_n` |
| dyn_width_en | input | 1 | Lets `bus_width_n` select 8-bit transfers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request is taken |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 16 | Read result |
| bus_width_n | input | 1 | Low: 8-bit transfer |
| ad_in | input | 16 | Shared lines as seen by the block |
| ad_out | output | 16 | Shared lines drive value |
| ad_oe_lo | output | 1 | Drive enable, lines 7:0 |
| ad_oe_hi | output | 1 | Drive enable, lines 15:8 |
| ale | output | 1 | Address latch pulse |
| adv_n | output | 1 | Address valid, low true |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| bhe_n | output | 1 | High byte enable |
| wrl_n | output | 1 | Low-lane write strobe |
| wrh_n | output | 1 | High-lane write strobe |

## Verification
The bench sweeps every strobe mode across three width settings, reads and writes, bytes and words, and even and odd addresses. It predicts every output in every phase from arithmetic alone.

- Odd-address byte accesses expose a design that ties the byte-high decode to the request size and ignores address bit 0. Such a design drives the wrong lane strobe or high enable.
- Width sampled low while `dyn_width_en`=0 catches a design that narrows the bus anyway. Its strobe counts and lane contents would come out wrong.
- Split word accesses catch a design that issues a single byte transfer, swaps the halves, or pulses `done` twice.
- Reads check that both lanes are released and that the unused byte is dropped rather than merged into `rd_data`.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_RCVR = 2'd3
    } phase_t;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic           req_word,
    input  logic [ADW-1:0] req_addr,
    input  logic [ADW-1:0] req_wdata,
    input  logic           dyn_width_en,
    input  logic           bus_width_n,
    output phase_t         phase,
    output logic           lat_write,
    output logic           lat_word,
    output logic [ADW-1:0] lat_addr,
    output logic [ADW-1:0] lat_wdata,
    output logic           cur_a0,
    output logic           wid8,
    output logic           done
);

    phase_t state_q, state_d;
    logic   wid8_q;
    logic   second_q;
    logic   done_q;
    logic   live_w8;
    logic   split_more;

    assign live_w8    = dyn_width_en && !bus_width_n;
    assign split_more = lat_word && wid8_q && !second_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (req_valid) state_d = PH_ADDR;
            PH_ADDR: state_d = PH_STRB;
            PH_STRB: state_d = PH_RCVR;
            PH_RCVR: state_d = split_more ? PH_ADDR : PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // request latch, width capture, split tracking, completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_word  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            wid8_q    <= 1'b0;
            second_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == PH_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_word  <= req_word;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                second_q  <= 1'b0;
            end
            if (state_q == PH_ADDR && !second_q)
                wid8_q <= live_w8;
            if (state_q == PH_RCVR) begin
                if (split_more) second_q <= 1'b1;
                else            done_q   <= 1'b1;
            end
        end
    end

    assign phase  = state_q;
    assign wid8   = (state_q == PH_ADDR && !second_q) ? live_w8 : wid8_q;
    assign cur_a0 = lat_word ? second_q : lat_addr[0];
    assign done   = done_q;

endmodule

// File: rtl/mbus_strobes.sv
module mbus_strobes
    import mbus_pkg::*;
(
    input  phase_t phase,
    input  logic   cfg_ale_mode,
    input  logic   cfg_wr_mode,
    input  logic   lat_write,
    input  logic   lat_word,
    input  logic   cur_a0,
    input  logic   wid8,
    output logic   ale,
    output logic   adv_n,
    output logic   rd_n,
    output logic   wr_n,
    output logic   bhe_n,
    output logic   wrl_n,
    output logic   wrh_n
);

    logic active;
    logic in_strb;
    logic touch_hi;
    logic wr_pulse;

    always_comb begin
        active   = (phase != PH_IDLE);
        in_strb  = (phase == PH_STRB);
        touch_hi = wid8 ? cur_a0 : (lat_word || cur_a0);
        wr_pulse = in_strb && lat_write;

        ale   = cfg_ale_mode && (phase == PH_ADDR);
        adv_n = !(!cfg_ale_mode && active);
        rd_n  = !(in_strb && !lat_write);

        if (cfg_wr_mode) begin
            wr_n  = !wr_pulse;
            bhe_n = !(active && touch_hi);
            wrl_n = 1'b1;
            wrh_n = 1'b1;
        end else begin
            wr_n  = 1'b1;
            bhe_n = 1'b1;
            wrl_n = !(wr_pulse && (wid8 || !cur_a0));
            wrh_n = !(wr_pulse && !wid8 && touch_hi);
        end
    end

endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
    import mbus_pkg::*;
#(
    parameter int ADW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  phase_t         phase,
    input  logic           lat_write,
    input  logic           lat_word,
    input  logic           cur_a0,
    input  logic           wid8,
    input  logic [ADW-1:0] lat_addr,
    input  logic [ADW-1:0] lat_wdata,
    input  logic [ADW-1:0] ad_in,
    output logic [ADW-1:0] ad_out,
    output logic           ad_oe_lo,
    output logic           ad_oe_hi,
    output logic [ADW-1:0] rd_data
);

    localparam int BW = ADW / 2;

    logic [BW-1:0]  addr_hi;
    logic [BW-1:0]  wbyte;
    logic [ADW-1:0] rd_q;

    assign addr_hi = lat_addr[ADW-1:BW];
    assign wbyte   = (lat_word && cur_a0) ? lat_wdata[ADW-1:BW] : lat_wdata[BW-1:0];

    always_comb begin
        ad_out   = '0;
        ad_oe_lo = 1'b0;
        ad_oe_hi = 1'b0;
        unique case (phase)
            PH_IDLE: ;
            PH_ADDR: begin
                ad_out   = {lat_addr[ADW-1:1], cur_a0};
                ad_oe_lo = 1'b1;
                ad_oe_hi = 1'b1;
            end
            PH_STRB: begin
                if (lat_write) begin
                    ad_oe_lo = 1'b1;
                    ad_oe_hi = 1'b1;
                    if (wid8)          ad_out = {addr_hi, wbyte};
                    else if (lat_word) ad_out = lat_wdata;
                    else               ad_out = {lat_wdata[BW-1:0], lat_wdata[BW-1:0]};
                end else begin
                    ad_oe_hi = wid8;
                    ad_out   = {addr_hi, {BW{1'b0}}};
                end
            end
            PH_RCVR: begin
                ad_oe_hi = wid8;
                ad_out   = {addr_hi, {BW{1'b0}}};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (phase == PH_STRB && !lat_write) begin
            if (wid8) begin
                if (!lat_word)   rd_q <= {{BW{1'b0}}, ad_in[BW-1:0]};
                else if (cur_a0) rd_q[ADW-1:BW] <= ad_in[BW-1:0];
                else             rd_q[BW-1:0]   <= ad_in[BW-1:0];
            end else begin
                if (lat_word)    rd_q <= ad_in;
                else if (cur_a0) rd_q <= {{BW{1'b0}}, ad_in[ADW-1:BW]};
                else             rd_q <= {{BW{1'b0}}, ad_in[BW-1:0]};
            end
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
    import mbus_pkg::*;
#(
    parameter int ADW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_ale_mode,
    input  logic           cfg_wr_mode,
    input  logic           dyn_width_en,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic           req_word,
    input  logic [ADW-1:0] req_addr,
    input  logic [ADW-1:0] req_wdata,
    output logic           done,
    output logic [ADW-1:0] rd_data,
    input  logic           bus_width_n,
    input  logic [ADW-1:0] ad_in,
    output logic [ADW-1:0] ad_out,
    output logic           ad_oe_lo,
    output logic           ad_oe_hi,
    output logic           ale,
    output logic           adv_n,
    output logic           rd_n,
    output logic           wr_n,
    output logic           bhe_n,
    output logic           wrl_n,
    output logic           wrh_n
);

    phase_t         phase;
    logic           lat_write;
    logic           lat_word;
    logic [ADW-1:0] lat_addr;
    logic [ADW-1:0] lat_wdata;
    logic           cur_a0;
    logic           wid8;

    mbus_seq #(.ADW(ADW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .dyn_width_en (dyn_width_en),
        .bus_width_n  (bus_width_n),
        .phase        (phase),
        .lat_write    (lat_write),
        .lat_word     (lat_word),
        .lat_addr     (lat_addr),
        .lat_wdata    (lat_wdata),
        .cur_a0       (cur_a0),
        .wid8         (wid8),
        .done         (done)
    );

    mbus_strobes u_strobes (
        .phase        (phase),
        .cfg_ale_mode (cfg_ale_mode),
        .cfg_wr_mode  (cfg_wr_mode),
        .lat_write    (lat_write),
        .lat_word     (lat_word),
        .cur_a0       (cur_a0),
        .wid8         (wid8),
        .ale          (ale),
        .adv_n        (adv_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .bhe_n        (bhe_n),
        .wrl_n        (wrl_n),
        .wrh_n        (wrh_n)
    );

    mbus_lanes #(.ADW(ADW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .lat_write (lat_write),
        .lat_word  (lat_word),
        .cur_a0    (cur_a0),
        .wid8      (wid8),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .ad_oe_lo  (ad_oe_lo),
        .ad_oe_hi  (ad_oe_hi),
        .rd_data   (rd_data)
    );

    assign req_ready = (phase == PH_IDLE);

endmodule

// File: rtl/mbus_strobe_gen_chk.sv
module mbus_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic ad_oe_lo,
    input logic ad_oe_hi,
    input logic ale,
    input logic adv_n,
    input logic rd_n,
    input logic wr_n,
    input logic bhe_n,
    input logic wrl_n,
    input logic wrh_n
);

    // R3: latch pulse only while the full address is driven and no strobe is active
    a_r3_ale_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe_lo && ad_oe_hi && rd_n && wr_n && wrl_n && wrh_n));

    // R3: the two address strobes never both active
    a_r3_ale_adv_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> adv_n);

    // R5: low lane released while reading
    a_r5_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe_lo);

    // R5: read strobe lasts one cycle
    a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);

    // R6: write strobe never overlaps read
    a_r6_wr_not_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (rd_n && wrl_n && wrh_n));

    // R8: split strobes exclude the single strobe and high enable
    a_r8_split_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrl_n || !wrh_n) |-> (wr_n && bhe_n && rd_n));

    // R2: completion is a single pulse seen while idle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

bind mbus_strobe_gen mbus_strobe_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ad_oe_lo  (ad_oe_lo),
    .ad_oe_hi  (ad_oe_hi),
    .ale       (ale),
    .adv_n     (adv_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bhe_n     (bhe_n),
    .wrl_n     (wrl_n),
    .wrh_n     (wrh_n)
);

// File: tb/mbus_strobe_gen_test.sv
module mbus_strobe_gen_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ale_mode = 1'b1;
    logic        cfg_wr_mode = 1'b1;
    logic        dyn_width_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic        bus_width_n = 1'b1;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe_lo, ad_oe_hi, ale, adv_n, rd_n, wr_n, bhe_n, wrl_n, wrh_n;

    int n_tests = 0;
    int n_fail  = 0;

    logic        t_is8 = 1'b0;
    logic [15:0] rd_a = '0;

    always #(CLK_P/2) clk = ~clk;

    mbus_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_ale_mode(cfg_ale_mode), .cfg_wr_mode(cfg_wr_mode),
        .dyn_width_en(dyn_width_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .bus_width_n(bus_width_n), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ale(ale), .adv_n(adv_n),
        .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .wrl_n(wrl_n), .wrh_n(wrh_n)
    );

    function automatic logic [7:0] mem(input logic [15:0] a);
        mem = (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model on the shared lines
    always_comb begin
        if (t_is8) ad_in = {8'hEE, mem(rd_a)};
        else       ad_in = {mem(rd_a | 16'h0001), mem(rd_a & 16'hFFFE)};
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_phase(input int p, input int k, input logic am, input logic wm,
                               input logic wr, input logic wd,
                               input logic [15:0] a, input logic [15:0] d);
        logic a0, hi, strb, oelo, oehi;
        logic [15:0] exp_ad, mask;
        logic [7:0]  byt;
        a0   = wd ? (t_is8 ? (k == 1) : 1'b0) : a[0];
        hi   = t_is8 ? a0 : (wd || a0);
        strb = (p == 1) && wr;
        byt  = (wd && k == 1) ? d[15:8] : d[7:0];
        oelo = (p == 0) || strb;
        oehi = (p == 0) || strb || t_is8;
        if (p == 0)     exp_ad = {a[15:1], a0};
        else if (strb)  exp_ad = t_is8 ? {a[15:8], byt} : (wd ? d : {d[7:0], d[7:0]});
        else            exp_ad = {a[15:8], 8'h00};
        mask = {oehi ? 8'hFF : 8'h00, oelo ? 8'hFF : 8'h00};

        chk("R2 req_ready busy", {15'd0, req_ready}, 16'd0);
        chk("R2 done quiet", {15'd0, done}, 16'd0);
        chk("R3 ale", {15'd0, ale}, {15'd0, am && p == 0});
        chk("R3 adv_n", {15'd0, adv_n}, {15'd0, am});
        chk("R4/R5/R11 ad_oe_lo", {15'd0, ad_oe_lo}, {15'd0, oelo});
        chk("R4/R5/R11 ad_oe_hi", {15'd0, ad_oe_hi}, {15'd0, oehi});
        chk("R4/R9/R11 ad_out", ad_out & mask, exp_ad & mask);
        chk("R5 rd_n", {15'd0, rd_n}, {15'd0, !(p == 1 && !wr)});
        chk("R6 wr_n", {15'd0, wr_n}, {15'd0, !(wm && strb)});
        chk("R7 bhe_n", {15'd0, bhe_n}, {15'd0, !(wm && hi)});
        chk("R8 wrl_n", {15'd0, wrl_n}, {15'd0, !(!wm && strb && (t_is8 || !a0))});
        chk("R8 wrh_n", {15'd0, wrh_n}, {15'd0, !(!wm && strb && !t_is8 && hi)});
    endtask

    task automatic run_txn(input logic am, input logic wm, input logic dy, input logic bn,
                           input logic wr, input logic wd,
                           input logic [15:0] a, input logic [15:0] d);
        int ncyc;
        logic [15:0] exp_rd;
        cfg_ale_mode = am;
        cfg_wr_mode  = wm;
        dyn_width_en = dy;
        bus_width_n  = bn;
        req_write    = wr;
        req_word     = wd;
        req_addr     = a;
        req_wdata    = d;
        req_valid    = 1'b1;
        t_is8        = dy && !bn;
        ncyc         = (wd && t_is8) ? 2 : 1;
        chk("R2 req_ready idle", {15'd0, req_ready}, 16'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            for (int p = 0; p < 3; p++) begin
                if (p == 0)
                    rd_a = wd ? {a[15:1], (t_is8 && k == 1)} : a;
                check_phase(p, k, am, wm, wr, wd, a, d);
                @(negedge clk);
            end
        end
        // R12: single completion after all byte transfers
        chk("R2/R12 done", {15'd0, done}, 16'd1);
        chk("R2 req_ready after", {15'd0, req_ready}, 16'd1);
        if (!wr) begin
            exp_rd = wd ? {mem({a[15:1], 1'b1}), mem({a[15:1], 1'b0})} : {8'h00, mem(a)};
            chk("R10 rd_data", rd_data, exp_rd);
        end
        @(negedge clk);
        chk("R2 done cleared", {15'd0, done}, 16'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] addrs [3];
        addrs[0] = 16'h12A4;
        addrs[1] = 16'hC3B5;
        addrs[2] = 16'h7F01;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {15'd0, req_ready}, 16'd1);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 ale", {15'd0, ale}, 16'd0);
        chk("R1 strobes", {9'd0, adv_n, rd_n, wr_n, bhe_n, wrl_n, wrh_n, 1'b0}, 16'h007E);
        chk("R1 enables", {14'd0, ad_oe_lo, ad_oe_hi}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {15'd0, req_ready}, 16'd1);
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 3; w++)      // R11: 0 disabled+low, 1 enabled+high, 2 enabled+low
                for (int op = 0; op < 4; op++)
                    for (int ai = 0; ai < 3; ai++)
                        run_txn(m[1], m[0], (w != 0), (w == 1), op[1], op[0],
                                addrs[ai], addrs[ai] ^ 16'h9C3E);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule